// File: doc/BRIEF.md
# Receive Character Queue with Trigger Interrupt and Automatic RTS

This block sits between a serial receiver and the host read path of a UART. Each received character is pushed in along with its parity-error, framing-error and break flags. The host sees the oldest stored character and its flags on the output and removes it with a pop strobe. The storage depth is chosen at run time. It can be a single holding register, a 16-entry queue or a 64-entry queue.

The fill level is compared against a trigger threshold taken from a 2-bit selector. When the level reaches that threshold, a data-available interrupt is raised. With automatic flow control enabled, the same comparison drops RTS so that the remote sender stops, and RTS rises again once the queue drains completely. There is also a character-timeout interrupt, which flags data that has sat unread with no queue activity for four character times. A line-status interrupt reports overrun and any error flag on the oldest entry. The three sources are combined into a single request.

Top module: `rxq_top`

## Requirements
- R1: The capacity is 1 entry for `mode_i`=0, 16 entries for `mode_i`=1 and 64 entries for `mode_i`=2 or 3. A push while the queue is at capacity, with no accepted pop in the same cycle, is discarded and leaves the stored contents unchanged.
- R2: Entries leave in arrival order. `head_*` outputs show the oldest entry's 8 data bits and its three flags. A pop removes that entry on the next clock edge, and a pop while empty has no effect. A push and a pop in the same cycle are both accepted.
- R3: A discarded push sets the sticky `overrun_o` on the next edge. `status_rd_i` clears it on the next edge, and a new overrun in the same cycle takes priority over the clear.
- R4: `data_ready_o` is 1 exactly when the queue holds one or more entries, for every trigger selection.
- R5: The trigger level is 1 in single mode. In 16-entry mode it is 1, 4, 8 or 14 and in 64-entry mode it is 1, 16, 32 or 56, for `trig_sel_i` = 0, 1, 2, 3 respectively. `irq_avail_o` is 1 exactly when the fill level is at least the trigger level.
- R6: An internal RTS state starts at 1 after reset. At each clock edge it becomes 0 if the fill level is at or above the trigger level, or 1 if the queue is empty, and otherwise keeps its value. `rts_o` follows that state when `afc_en_i` is 1 and is 1 when `afc_en_i` is 0.
- R7: `irq_timeout_o` is 1 when the queue is non-empty and 4×`char_cycles_i` clock edges have passed since the last accepted push, accepted pop or flush. It stays 0 when `char_cycles_i` is 0.
- R8: `clear_i`, or a `mode_i` value differing from the current mode, empties the queue on the next edge and resets both pointers. A push or pop presented in that cycle is ignored.
- R9: `irq_o` is the OR of `irq_avail_o`, `irq_timeout_o`, `overrun_o` and, when data is present, any error flag of the oldest entry.
- R10: After reset the queue is empty, the mode is single, `overrun_o` is 0 and `rts_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Depth mode: 0 single, 1 sixteen, 2/3 sixty-four |
| trig_sel_i | input | 2 | Trigger level selector |
| afc_en_i | input | 1 | Automatic RTS flow control enable |
| clear_i | input | 1 | Empty the queue |
| char_cycles_i | input | 16 | Clock cycles per character time |
| push_i | input | 1 | Receiver push strobe |
| push_data_i | input | 8 | Received character |
| push_perr_i | input | 1 | Parity error for the character |
| push_ferr_i | input | 1 | Framing error for the character |
| push_brk_i | input | 1 | Break indication for the character |
| pop_i | input | 1 | Host read strobe |
| status_rd_i | input | 1 | Host status read, clears overrun |
| head_data_o | output | 8 | Oldest character |
| head_perr_o | output | 1 | Parity error of oldest entry |
| head_ferr_o | output | 1 | Framing error of oldest entry |
| head_brk_o | output | 1 | Break flag of oldest entry |
| data_ready_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky overrun flag |
| irq_avail_o | output | 1 | Fill level at or above trigger |
| irq_timeout_o | output | 1 | Character timeout |
| irq_o | output | 1 | Combined receive interrupt |
| rts_o | output | 1 | Request-to-send toward remote sender |

## Verification
The fill level, the head entry, `data_ready_o`, `overrun_o` and the trigger interrupt all settle one clock edge after the push, pop, clear or status-read strobe that changes them. The bench steps its reference queue at that same edge and compares 1 ns after it. `rts_o` follows the fill level one edge later than that, because it is updated from the registered level, so the reference model updates RTS from the level that stood before the step. The timeout is due exactly 4×`char_cycles_i` edges after the last activity. Directed runs check the edge just before that deadline and the edge at it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        DM_SINGLE = 2'd0,
        DM_MID    = 2'd1,
        DM_MAX    = 2'd2,
        DM_MAX_B  = 2'd3
    } depth_mode_e;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

    function automatic int unsigned mode_capacity(depth_mode_e m, int unsigned mid_depth,
                                                  int unsigned max_depth);
        case (m)
            DM_SINGLE: return 1;
            DM_MID:    return mid_depth;
            default:   return max_depth;
        endcase
    endfunction

    function automatic int unsigned trig_level(depth_mode_e m, logic [1:0] sel,
                                               int unsigned mid_depth, int unsigned max_depth);
        int unsigned depth;
        int unsigned gap;
        if (m == DM_SINGLE) return 1;
        depth = (m == DM_MID) ? mid_depth : max_depth;
        gap   = (m == DM_MID) ? 2 : 8;
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - gap;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned MID_DEPTH = 16,
    parameter int unsigned MAX_DEPTH = 64,
    localparam int unsigned PTR_W = $clog2(MAX_DEPTH),
    localparam int unsigned CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_i,
    input  logic             clear_i,
    input  logic             push_i,
    input  rx_entry_t        push_ent_i,
    input  logic             pop_i,
    input  logic             status_rd_i,
    output rx_entry_t        head_o,
    output logic [CNT_W-1:0] count_o,
    output depth_mode_e      mode_o,
    output logic             overrun_o,
    output logic             activity_o
);

    rx_entry_t        mem [MAX_DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count, cap;
    depth_mode_e      mode_q;
    logic             overrun_q;
    logic             flush, full, pop_ok, push_ok, ovr_set;

    function automatic logic [PTR_W-1:0] ptr_step(logic [PTR_W-1:0] p, logic [CNT_W-1:0] c);
        if ({1'b0, p} == CNT_W'(c - 1'b1)) return '0;
        return p + 1'b1;
    endfunction

    assign cap     = CNT_W'(mode_capacity(mode_q, MID_DEPTH, MAX_DEPTH));
    assign flush   = clear_i || (depth_mode_e'(mode_i) != mode_q);
    assign full    = (count == cap);
    assign pop_ok  = pop_i && (count != '0) && !flush;
    assign push_ok = push_i && !flush && (!full || pop_ok);
    assign ovr_set = push_i && !flush && full && !pop_ok;

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_ent_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            mode_q    <= DM_SINGLE;
            overrun_q <= 1'b0;
        end else begin
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
                mode_q <= depth_mode_e'(mode_i);
            end else begin
                if (push_ok) wr_ptr <= ptr_step(wr_ptr, cap);
                if (pop_ok)  rd_ptr <= ptr_step(rd_ptr, cap);
                if (push_ok && !pop_ok)      count <= count + 1'b1;
                else if (pop_ok && !push_ok) count <= count - 1'b1;
            end
            if (ovr_set)          overrun_q <= 1'b1;
            else if (status_rd_i) overrun_q <= 1'b0;
        end
    end

    assign head_o     = mem[rd_ptr];
    assign count_o    = count;
    assign mode_o     = mode_q;
    assign overrun_o  = overrun_q;
    assign activity_o = push_ok || pop_ok || flush;

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= cap);
    a_r3_overrun_set: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !flush && count == cap) |=> overrun_q);
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));
    a_r2_pop_empty_idle: assert property (@(posedge clk) disable iff (rst)
        (count == '0 && !push_i) |=> (count == '0));

endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
    import rxq_pkg::*;
#(
    parameter int unsigned MID_DEPTH = 16,
    parameter int unsigned MAX_DEPTH = 64,
    localparam int unsigned CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  depth_mode_e      mode_i,
    input  logic [1:0]       trig_sel_i,
    input  logic             afc_en_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             irq_avail_o,
    output logic             rts_o
);

    logic [CNT_W-1:0] level;
    logic             rts_q;

    assign level       = CNT_W'(trig_level(mode_i, trig_sel_i, MID_DEPTH, MAX_DEPTH));
    assign irq_avail_o = (count_i >= level);

    always_ff @(posedge clk) begin
        if (rst)                  rts_q <= 1'b1;
        else if (count_i >= level) rts_q <= 1'b0;
        else if (count_i == '0)   rts_q <= 1'b1;
    end

    assign rts_o = afc_en_i ? rts_q : 1'b1;

    a_r6_rts_drop: assert property (@(posedge clk) disable iff (rst)
        (count_i >= level) |=> !rts_q);
    a_r6_rts_rise: assert property (@(posedge clk) disable iff (rst)
        (count_i == '0) |=> rts_q);
    a_r5_empty_no_avail: assert property (@(posedge clk) disable iff (rst)
        (count_i == '0) |-> !irq_avail_o);

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
    parameter int unsigned CHAR_W = 16,
    localparam int unsigned TMO_W = CHAR_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAR_W-1:0] char_cycles_i,
    input  logic              activity_i,
    input  logic              nonempty_i,
    output logic              irq_timeout_o
);

    logic [TMO_W-1:0] idle_cnt;
    logic [TMO_W-1:0] limit;

    assign limit = {char_cycles_i, 2'b00};

    always_ff @(posedge clk) begin
        if (rst || activity_i || !nonempty_i) idle_cnt <= '0;
        else if (idle_cnt < limit)            idle_cnt <= idle_cnt + 1'b1;
    end

    assign irq_timeout_o = nonempty_i && (limit != '0) && (idle_cnt >= limit);

    a_r7_empty_quiet: assert property (@(posedge clk) disable iff (rst)
        !nonempty_i |-> !irq_timeout_o);
    a_r7_activity_restarts: assert property (@(posedge clk) disable iff (rst)
        (activity_i && char_cycles_i != '0 && $stable(char_cycles_i)) |=> !irq_timeout_o);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int unsigned MID_DEPTH = 16,
    parameter int unsigned MAX_DEPTH = 64,
    parameter int unsigned CHAR_W    = 16,
    localparam int unsigned CNT_W = $clog2(MAX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        trig_sel_i,
    input  logic              afc_en_i,
    input  logic              clear_i,
    input  logic [CHAR_W-1:0] char_cycles_i,
    input  logic              push_i,
    input  logic [7:0]        push_data_i,
    input  logic              push_perr_i,
    input  logic              push_ferr_i,
    input  logic              push_brk_i,
    input  logic              pop_i,
    input  logic              status_rd_i,
    output logic [7:0]        head_data_o,
    output logic              head_perr_o,
    output logic              head_ferr_o,
    output logic              head_brk_o,
    output logic              data_ready_o,
    output logic              overrun_o,
    output logic              irq_avail_o,
    output logic              irq_timeout_o,
    output logic              irq_o,
    output logic              rts_o
);

    rx_entry_t        push_ent, head;
    logic [CNT_W-1:0] count;
    depth_mode_e      mode_q;
    logic             activity;
    logic             line_err;

    assign push_ent = '{brk: push_brk_i, ferr: push_ferr_i, perr: push_perr_i, data: push_data_i};

    rxq_store #(.MID_DEPTH(MID_DEPTH), .MAX_DEPTH(MAX_DEPTH)) u_store (
        .clk(clk), .rst(rst), .mode_i(mode_i), .clear_i(clear_i),
        .push_i(push_i), .push_ent_i(push_ent), .pop_i(pop_i),
        .status_rd_i(status_rd_i), .head_o(head), .count_o(count),
        .mode_o(mode_q), .overrun_o(overrun_o), .activity_o(activity)
    );

    rxq_flow #(.MID_DEPTH(MID_DEPTH), .MAX_DEPTH(MAX_DEPTH)) u_flow (
        .clk(clk), .rst(rst), .mode_i(mode_q), .trig_sel_i(trig_sel_i),
        .afc_en_i(afc_en_i), .count_i(count),
        .irq_avail_o(irq_avail_o), .rts_o(rts_o)
    );

    rxq_timeout #(.CHAR_W(CHAR_W)) u_tmo (
        .clk(clk), .rst(rst), .char_cycles_i(char_cycles_i),
        .activity_i(activity), .nonempty_i(count != '0),
        .irq_timeout_o(irq_timeout_o)
    );

    assign data_ready_o = (count != '0);
    assign head_data_o  = head.data;
    assign head_perr_o  = head.perr;
    assign head_ferr_o  = head.ferr;
    assign head_brk_o   = head.brk;
    assign line_err     = data_ready_o && (head.perr || head.ferr || head.brk);
    assign irq_o        = irq_avail_o || irq_timeout_o || overrun_o || line_err;

    a_r9_irq_sources: assert property (@(posedge clk) disable iff (rst)
        overrun_o |-> irq_o);
    a_r4_ready_on_avail: assert property (@(posedge clk) disable iff (rst)
        irq_avail_o |-> data_ready_o);

endmodule

// File: tb/test_rxq_top.sv
`timescale 1ns/100ps
module test_rxq_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = 2'd0;
    logic [1:0]  trig_sel_i = 2'd0;
    logic        afc_en_i = 1'b1;
    logic        clear_i = 1'b0;
    logic [15:0] char_cycles_i = 16'd1000;
    logic        push_i = 1'b0;
    logic [7:0]  push_data_i = 8'd0;
    logic        push_perr_i = 1'b0, push_ferr_i = 1'b0, push_brk_i = 1'b0;
    logic        pop_i = 1'b0;
    logic        status_rd_i = 1'b0;
    logic [7:0]  head_data_o;
    logic        head_perr_o, head_ferr_o, head_brk_o;
    logic        data_ready_o, overrun_o, irq_avail_o, irq_timeout_o, irq_o, rts_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit chk_tmo = 1'b1;

    logic [10:0] mq[$];
    logic [1:0]  mmode = 2'd0;
    bit          mov = 1'b0;
    bit          mrts = 1'b1;

    always #2.5 clk = ~clk;

    rxq_top i_rxq_top (
        .clk(clk), .rst(rst), .mode_i(mode_i), .trig_sel_i(trig_sel_i),
        .afc_en_i(afc_en_i), .clear_i(clear_i), .char_cycles_i(char_cycles_i),
        .push_i(push_i), .push_data_i(push_data_i), .push_perr_i(push_perr_i),
        .push_ferr_i(push_ferr_i), .push_brk_i(push_brk_i), .pop_i(pop_i),
        .status_rd_i(status_rd_i), .head_data_o(head_data_o), .head_perr_o(head_perr_o),
        .head_ferr_o(head_ferr_o), .head_brk_o(head_brk_o), .data_ready_o(data_ready_o),
        .overrun_o(overrun_o), .irq_avail_o(irq_avail_o), .irq_timeout_o(irq_timeout_o),
        .irq_o(irq_o), .rts_o(rts_o)
    );

    function automatic int cap_of(logic [1:0] m);
        return (m == 2'd0) ? 1 : (m == 2'd1) ? 16 : 64;
    endfunction

    function automatic int lvl_of(logic [1:0] m, logic [1:0] s);
        if (m == 2'd0) return 1;
        if (m == 2'd1) return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
        return (s == 0) ? 1 : (s == 1) ? 16 : (s == 2) ? 32 : 56;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [10:0] hd;
        bit ne, ex_avail, ex_irq, ex_rts;
        ne = mq.size() > 0;
        hd = ne ? mq[0] : 11'h0;
        ex_avail = mq.size() >= lvl_of(mmode, trig_sel_i);
        ex_rts = afc_en_i ? mrts : 1'b1;
        ex_irq = ex_avail || mov || (ne && (hd[10:8] != 0)) || (chk_tmo ? 1'b0 : irq_timeout_o);
        chk("R4 data_ready", 32'(data_ready_o), 32'(ne));
        if (ne) chk("R2 head entry", 32'({head_brk_o, head_ferr_o, head_perr_o, head_data_o}), 32'(hd));
        chk("R3 overrun", 32'(overrun_o), 32'(mov));
        chk("R5 irq_avail", 32'(irq_avail_o), 32'(ex_avail));
        chk("R6 rts", 32'(rts_o), 32'(ex_rts));
        if (chk_tmo) chk("R7 timeout idle", 32'(irq_timeout_o), 32'd0);
        chk("R9 irq", 32'(irq_o), 32'(ex_irq));
    endtask

    task automatic step(bit psh, logic [10:0] ent, bit pp, bit srd, bit clr,
                        logic [1:0] md, logic [1:0] ts, bit afc);
        int  cpre;
        bit  popok, set;
        push_i = psh; {push_brk_i, push_ferr_i, push_perr_i, push_data_i} = ent;
        pop_i = pp; status_rd_i = srd; clear_i = clr; mode_i = md;
        trig_sel_i = ts; afc_en_i = afc;
        @(posedge clk);
        cpre = mq.size();
        if (cpre >= lvl_of(mmode, ts)) mrts = 1'b0;
        else if (cpre == 0) mrts = 1'b1;
        if (clr || md != mmode) begin
            mq.delete();
            mmode = md;
            if (srd) mov = 1'b0;
        end else begin
            popok = pp && mq.size() > 0;
            set = psh && mq.size() >= cap_of(mmode) && !popok;
            if (popok) void'(mq.pop_front());
            if (psh && !set) mq.push_back(ent);
            if (set) mov = 1'b1;
            else if (srd) mov = 1'b0;
        end
        #1;
        compare_all();
        push_i = 1'b0; pop_i = 1'b0; status_rd_i = 1'b0; clear_i = 1'b0;
    endtask

    task automatic idle(logic [1:0] md, logic [1:0] ts);
        step(1'b0, 11'h0, 1'b0, 1'b0, 1'b0, md, ts, 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int phase;
        logic [1:0] rmode, rts_sel;
        bit rafc;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        // R10 reset state
        chk("R10 empty after reset", 32'(data_ready_o), 32'd0);
        chk("R10 overrun after reset", 32'(overrun_o), 32'd0);
        chk("R10 rts after reset", 32'(rts_o), 32'd1);
        chk("R10 irq after reset", 32'(irq_o), 32'd0);

        // R1 single mode: second push discarded
        step(1'b1, 11'h0A5, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1);
        step(1'b1, 11'h03C, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1);
        chk("R1 single keeps first", 32'(head_data_o), 32'h0A5);
        chk("R3 overrun on full single", 32'(overrun_o), 32'd1);
        // R3 status read clears, then set wins over clear
        step(1'b0, 11'h0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1);
        chk("R3 cleared by status read", 32'(overrun_o), 32'd0);
        step(1'b1, 11'h011, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1);
        chk("R3 set beats clear", 32'(overrun_o), 32'd1);
        // R1 single mode: push with pop accepted
        step(1'b1, 11'h122, 1'b1, 1'b1, 1'b0, 2'd0, 2'd0, 1'b1);
        chk("R1 push with pop in single", 32'({head_perr_o, head_data_o}), 32'h122);

        // R8 mode change flushes, R1 sixteen capacity
        step(1'b1, 11'h055, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 1'b1);
        chk("R8 mode change empties", 32'(data_ready_o), 32'd0);
        for (int i = 0; i < 17; i++) step(1'b1, 11'(i + 8'h40), 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 1'b1);
        chk("R1 sixteen overrun on 17th", 32'(overrun_o), 32'd1);
        for (int i = 0; i < 16; i++) begin
            chk("R2 order sixteen", 32'(head_data_o), 32'(i + 8'h40));
            step(1'b0, 11'h0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd3, 1'b1);
        end
        chk("R1 sixteen holds sixteen", 32'(data_ready_o), 32'd0);
        step(1'b0, 11'h0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd3, 1'b1);
        chk("R2 pop on empty ignored", 32'(data_ready_o), 32'd0);

        // R8 clear strobe
        step(1'b1, 11'h777, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b1);
        step(1'b1, 11'h012, 1'b0, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1);
        chk("R8 clear empties and drops push", 32'(data_ready_o), 32'd0);

        // R7 timeout at 4 character times
        char_cycles_i = 16'd3;
        chk_tmo = 1'b0;
        step(1'b1, 11'h061, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 1'b1);
        for (int k = 1; k <= 12; k++) begin
            idle(2'd1, 2'd3);
            chk("R7 timeout deadline", 32'(irq_timeout_o), 32'(k >= 12));
        end
        step(1'b1, 11'h062, 1'b0, 1'b0, 1'b0, 2'd1, 2'd3, 1'b1);
        chk("R7 push restarts timer", 32'(irq_timeout_o), 32'd0);
        for (int k = 1; k <= 5; k++) idle(2'd1, 2'd3);
        step(1'b0, 11'h0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd3, 1'b1);
        for (int k = 1; k <= 12; k++) begin
            idle(2'd1, 2'd3);
            chk("R7 after pop restart", 32'(irq_timeout_o), 32'(k >= 12));
        end
        char_cycles_i = 16'd0;
        for (int k = 0; k < 3; k++) idle(2'd1, 2'd3);
        chk("R7 zero char time never fires", 32'(irq_timeout_o), 32'd0);
        step(1'b0, 11'h0, 1'b0, 1'b0, 1'b1, 2'd1, 2'd3, 1'b1);
        char_cycles_i = 16'd1000;
        chk_tmo = 1'b1;

        // Random traffic across modes, triggers and flow control
        rmode = 2'd2; rts_sel = 2'd1; rafc = 1'b1;
        for (int n = 0; n < 6000; n++) begin
            phase = (n / 150) % 2;
            if (n % 150 == 0) begin
                rts_sel = 2'($urandom_range(0, 3));
                rafc = ($urandom_range(0, 3) != 0);
            end
            if ($urandom_range(0, 499) == 0) rmode = 2'($urandom_range(0, 3));
            step(($urandom_range(0, 9) < (phase == 0 ? 8 : 3)),
                 11'($urandom),
                 ($urandom_range(0, 9) < (phase == 0 ? 2 : 7)),
                 ($urandom_range(0, 19) == 0),
                 ($urandom_range(0, 799) == 0),
                 rmode, rts_sel, rafc);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule